// File: doc/BRIEF.md
# Two-Wire Bus Slave with 20-Byte Register Window

This block is a slave on a two-wire serial bus (I2C-style). It sits between the bus pins and a small register array owned by the surrounding logic. The raw clock and data lines are synchronized to the system clock, and the block watches them for start and stop conditions. It answers one fixed 7-bit device address. After a write-form address, the first byte sets an internal register pointer. Every later byte in the same transfer is written through a one-cycle strobe. After a read-form address, bytes are shifted out from the pointer, most significant bit first, for as long as the master keeps acknowledging. The pointer moves on after every data byte and wraps at the end of the window. A power-fail input overrides everything else: it drops the transfer, clears the pointer and makes the block deaf to the bus.

The data line is never driven high. The block only asserts `sda_pull`, an active-high enable for an external open-drain pull-down. The register array is reached through a plain address, write strobe and write data port, and read data comes back combinationally on `reg_rdata`.

The controller has eight named states:
- `ST_IDLE`: waits for a start condition.
- `ST_ADDR`: shifts in the address byte.
- `ST_ACK_ADR`: acknowledges the address.
- `ST_WPTR`: receives the pointer byte.
- `ST_WDATA`: receives a write byte.
- `ST_ACK_WR`: acknowledges a pointer byte or a write byte.
- `ST_RDATA`: shifts out a read byte.
- `ST_RACK`: samples the master's acknowledge.

Transitions:
- A start condition moves any state to `ST_ADDR`. A stop condition moves any state to `ST_IDLE`. Power-fail forces `ST_IDLE`.
- `ST_ADDR` goes to `ST_ACK_ADR` on a matching address and to `ST_IDLE` otherwise.
- `ST_ACK_ADR` goes to `ST_WPTR` for the write form and to `ST_RDATA` for the read form.
- `ST_WPTR` and `ST_WDATA` go to `ST_ACK_WR`, which goes to `ST_WDATA`.
- `ST_RDATA` goes to `ST_RACK`. `ST_RACK` returns to `ST_RDATA` on an acknowledge and falls to `ST_IDLE` on a not-acknowledge.

Top module: `twire_reg_slave`

## Requirements
- R1: A falling data line while the clock line is high (start) enters address reception from any state. A rising data line while the clock line is high (stop) returns the block to idle. After a stop, clocked bits are not acknowledged until the next start.
- R2: `sda_pull` changes only while the synchronized clock line is low, so the data line holds steady through each clock-high phase.
- R3: Only the address byte 0xD0 (7-bit address 0x68 with bit 0 = 0, write) or 0xD1 (bit 0 = 1, read) is acknowledged by pulling the data line low in the ninth clock. Any other address leaves the line released, and later bytes are ignored until the next start.
- R4: The first byte after a write-form address loads the pointer and is acknowledged. A value of 20 or more loads 0.
- R5: Each further byte of a write transfer is acknowledged and written to the pointer index with a single-cycle `reg_we` pulse.
- R6: The pointer advances by one after every data byte written or read, and wraps from 19 to 0. No limit applies to the number of bytes in a transfer.
- R7: In a read transfer, bytes come from the pointer index, most significant bit first. An acknowledge from the master continues with the next index. A not-acknowledge releases the data line, and no further bits are driven and the pointer does not move until the next start.
- R8: A repeated start returns to address matching with the pointer kept, so a pointer write followed by a read-form address reads from that pointer.
- R9: While `pwr_fail` is high, `sda_pull` is low, the pointer is 0, and bus activity is neither acknowledged nor written.
- R10: When `pwr_fail` is high in the same cycle that a write byte completes, no write strobe is issued and the pointer ends at 0.
- R11: Out of reset, `sda_pull` and `reg_we` are low and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_fail | input | 1 | Power-fail indication; aborts and blocks bus access |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line (wired level) |
| sda_pull | output | 1 | Active-high open-drain pull-down enable for the data line |
| reg_addr | output | ADDR_W (5) | Register pointer, also the array read/write index |
| reg_we | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Byte to write |
| reg_rdata | input | 8 | Array byte at `reg_addr` |

## Verification
Completing a write byte and a power-fail can fall on the same system-clock edge. On that edge the write strobe, the pointer increment and the pointer clear all compete. The bench provokes this by counting the synchronizer stages and the edge-detect register behind a falling clock line, then raising `pwr_fail` for exactly the one cycle in which that falling edge is acted on. It judges the result from three observations: no `reg_we` pulse was seen, the model array byte at the target index is unchanged, and `reg_addr` reads 0.

// File: rtl/twr_pkg.sv
`timescale 1ns/1ps
package twr_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_ADR,
        ST_WPTR,
        ST_WDATA,
        ST_ACK_WR,
        ST_RDATA,
        ST_RACK
    } twr_state_e;
endpackage

// File: rtl/twr_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for the bus lines, plus one extra stage of history
// so that edges can be found. Lines reset to the idle-high level.
module twr_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic [WIDTH-1:0] dout_q
);
    logic [STAGES-1:0][WIDTH-1:0] pipe;
    logic [WIDTH-1:0]             hist;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= '1;
            hist <= '1;
        end else begin
            pipe <= {pipe[STAGES-2:0], din};
            hist <= pipe[STAGES-1];
        end
    end

    assign dout   = pipe[STAGES-1];
    assign dout_q = hist;
endmodule

// File: rtl/twr_cond.sv
`timescale 1ns/1ps
// Bus condition decode from current and previous synchronized levels.
module twr_cond (
    input  logic scl,
    input  logic scl_q,
    input  logic sda,
    input  logic sda_q,
    output logic start,
    output logic stop,
    output logic rise,
    output logic fall
);
    always_comb begin
        start = scl & scl_q & sda_q & ~sda;
        stop  = scl & scl_q & ~sda_q & sda;
        rise  = scl & ~scl_q;
        fall  = ~scl & scl_q;
    end
endmodule

// File: rtl/twr_ptr.sv
`timescale 1ns/1ps
// Register pointer: clear beats load beats increment; wraps at COUNT-1.
module twr_ptr #(
    parameter int COUNT = 20,
    parameter int W     = $clog2(COUNT)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [7:0]   load_val,
    input  logic         inc,
    output logic [W-1:0] ptr
);
    localparam logic [W-1:0] LAST = W'(COUNT - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (clr) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= (int'(load_val) < COUNT) ? load_val[W-1:0] : '0;
        end else if (inc) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

    p_ptr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ptr) < COUNT)
        else $error("pointer out of window");

    p_pf_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (ptr == '0))
        else $error("pointer not cleared by power-fail");
endmodule

// File: rtl/twire_reg_slave.sv
`timescale 1ns/1ps
module twire_reg_slave
    import twr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h68,
    parameter int         REG_COUNT   = 20,
    parameter int         SYNC_STAGES = 2,
    parameter int         ADDR_W      = $clog2(REG_COUNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_fail,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_we,
    output logic [7:0]        reg_wdata,
    input  logic [7:0]        reg_rdata
);
    localparam int               BYTE_BITS = 8;
    localparam int               CNT_W     = $clog2(BYTE_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(BYTE_BITS);

    logic [1:0] bus_s, bus_q;
    logic       scl_s, sda_s, scl_q, sda_q;
    logic       cond_start, cond_stop, scl_rise, scl_fall;

    twr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    ({scl_in, sda_in}),
        .dout   (bus_s),
        .dout_q (bus_q)
    );

    assign scl_s = bus_s[1];
    assign sda_s = bus_s[0];
    assign scl_q = bus_q[1];
    assign sda_q = bus_q[0];

    twr_cond u_cond (
        .scl   (scl_s),
        .scl_q (scl_q),
        .sda   (sda_s),
        .sda_q (sda_q),
        .start (cond_start),
        .stop  (cond_stop),
        .rise  (scl_rise),
        .fall  (scl_fall)
    );

    twr_state_e       state_q, state_d;
    logic [7:0]       shreg, txreg;
    logic [CNT_W-1:0] bitcnt;
    logic             rd_mode;
    logic             byte_end;
    logic             ptr_load, ptr_inc;

    assign byte_end = scl_fall && (bitcnt == CNT_FULL);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (pwr_fail) begin
            state_d = ST_IDLE;
        end else if (cond_start) begin
            state_d = ST_ADDR;
        end else if (cond_stop) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_IDLE;
                ST_ADDR:    if (byte_end)
                                state_d = (shreg[7:1] == DEV_ADDR) ? ST_ACK_ADR : ST_IDLE;
                ST_ACK_ADR: if (scl_fall) state_d = rd_mode ? ST_RDATA : ST_WPTR;
                ST_WPTR:    if (byte_end) state_d = ST_ACK_WR;
                ST_WDATA:   if (byte_end) state_d = ST_ACK_WR;
                ST_ACK_WR:  if (scl_fall) state_d = ST_WDATA;
                ST_RDATA:   if (byte_end) state_d = ST_RACK;
                ST_RACK:    if (scl_rise && sda_s) state_d = ST_IDLE;
                            else if (scl_fall)     state_d = ST_RDATA;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // Shift registers and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            txreg   <= '0;
            bitcnt  <= '0;
            rd_mode <= 1'b0;
        end else if (pwr_fail || cond_start) begin
            bitcnt <= '0;
        end else if (scl_rise) begin
            shreg <= {shreg[6:0], sda_s};
            if (bitcnt != CNT_FULL) bitcnt <= bitcnt + 1'b1;
        end else if (scl_fall) begin
            if (state_d != state_q) bitcnt <= '0;
            if (state_q == ST_ADDR && byte_end) rd_mode <= shreg[0];
            if (state_d == ST_RDATA && state_q != ST_RDATA) txreg <= reg_rdata;
            else if (state_q == ST_RDATA) txreg <= {txreg[6:0], 1'b0};
        end
    end

    // Outputs
    always_comb begin
        sda_pull = 1'b0;
        unique case (state_q)
            ST_ACK_ADR, ST_ACK_WR: sda_pull = 1'b1;
            ST_RDATA:              sda_pull = ~txreg[7];
            default:               sda_pull = 1'b0;
        endcase
        if (pwr_fail) sda_pull = 1'b0;
        reg_we    = (state_q == ST_WDATA) && byte_end && !pwr_fail;
        reg_wdata = shreg;
        ptr_load  = (state_q == ST_WPTR) && byte_end && !pwr_fail;
        ptr_inc   = (state_q == ST_WDATA || state_q == ST_RDATA) && byte_end && !pwr_fail;
    end

    twr_ptr #(.COUNT(REG_COUNT), .W(ADDR_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (pwr_fail),
        .load     (ptr_load),
        .load_val (shreg),
        .inc      (ptr_inc),
        .ptr      (reg_addr)
    );

    p_start_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_start && !pwr_fail) |=> (state_q == ST_ADDR))
        else $error("start not followed by address phase");

    p_stop_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_stop && !pwr_fail) |=> (state_q == ST_IDLE && !sda_pull))
        else $error("stop not followed by idle");

    p_sda_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_fail && !$past(pwr_fail) && (sda_pull != $past(sda_pull))) |-> !scl_s)
        else $error("data line changed while clock high");

    p_addr_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR && byte_end && !pwr_fail && shreg[7:1] != DEV_ADDR) |=> !sda_pull)
        else $error("foreign address acknowledged");

    p_we_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> (reg_addr == (($past(reg_addr) == ADDR_W'(REG_COUNT - 1)) ?
                                 '0 : $past(reg_addr) + 1'b1)))
        else $error("pointer did not advance after write");

    p_pf_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |-> !reg_we)
        else $error("write during power-fail");
endmodule

// File: tb/twire_reg_slave_tb.sv
`timescale 1ns/1ps
module twire_reg_slave_tb;
    localparam int Q = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_fail = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_in, sda_pull, reg_we;
    logic [4:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic [7:0] mem [20];
    int         n_chk = 0, n_fail = 0, we_cnt = 0, glitch = 0;
    bit         done = 0;

    always #4 clk = ~clk;

    assign sda_in    = m_sda & ~sda_pull;
    assign reg_rdata = mem[reg_addr];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 20; i++) mem[i] <= 8'(8'h40 + i);
        end else if (reg_we) begin
            mem[reg_addr] <= reg_wdata;
            we_cnt <= we_cnt + 1;
        end
    end

    twire_reg_slave u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_fail  (pwr_fail),
        .scl_in    (m_scl),
        .sda_in    (sda_in),
        .sda_pull  (sda_pull),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    // pointer, data, expected index
    localparam logic [23:0] VEC [6] = '{
        {8'd0,   8'hA5, 8'd0},
        {8'd7,   8'h3C, 8'd7},
        {8'd19,  8'h81, 8'd19},
        {8'd20,  8'h5E, 8'd0},
        {8'd200, 8'hC3, 8'd0},
        {8'd12,  8'h00, 8'd12}
    };

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; step(Q);
        m_scl = 1'b1; step(Q);
        m_sda = 1'b0; step(Q);
        m_scl = 1'b0; step(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; step(Q);
        m_scl = 1'b1; step(Q);
        m_sda = 1'b1; step(Q);
    endtask

    task automatic send_bits(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; step(Q);
            m_scl = 1'b1; step(Q);
            m_scl = 1'b0; step(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b);
        m_sda = 1'b1; step(Q);
        m_scl = 1'b1; step(Q);
        ack = sda_in;
        m_scl = 1'b0; step(Q);
    endtask

    task automatic recv_byte(input logic m_ack, output logic [7:0] d);
        logic a;
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            step(Q);
            m_scl = 1'b1; step(1);
            a = sda_in;
            step(Q);
            if (a !== sda_in) glitch++;
            d[i] = sda_in;
            m_scl = 1'b0;
        end
        step(Q);
        m_sda = m_ack ? 1'b0 : 1'b1; step(Q);
        m_scl = 1'b1; step(Q);
        m_scl = 1'b0; step(Q);
        m_sda = 1'b1;
    endtask

    task automatic rep_start();
        m_sda = 1'b1; step(Q);
        m_scl = 1'b1; step(Q);
        m_sda = 1'b0; step(Q);
        m_scl = 1'b0; step(Q);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic       ack;
        logic [7:0] d;
        int         we0;

        step(5);
        // R11 reset state
        chk("R11 sda_pull", sda_pull, 0);
        chk("R11 reg_we", reg_we, 0);
        chk("R11 reg_addr", reg_addr, 0);
        rst_n = 1'b1;
        step(Q);

        // Vector table: write one byte, then read it back via repeated start
        foreach (VEC[k]) begin
            logic [7:0] p, v, e;
            {p, v, e} = VEC[k];
            bus_start();
            send_byte(8'hD0, ack); chk("R3 write address ack", ack, 0);
            send_byte(p, ack);     chk("R4 pointer ack", ack, 0);
            send_byte(v, ack);     chk("R5 data ack", ack, 0);
            bus_stop();
            chk("R5 array byte", mem[e], v);
            chk("R6 pointer after write", reg_addr, (e == 19) ? 0 : e + 1);
            bus_start();
            send_byte(8'hD0, ack);
            send_byte(p, ack);
            rep_start();
            send_byte(8'hD1, ack); chk("R8 read address ack", ack, 0);
            recv_byte(1'b0, d);
            bus_stop();
            chk("R7 read data msb first", d, v);
            chk("R6 pointer after read", reg_addr, (e == 19) ? 0 : e + 1);
        end

        // R3 foreign address ignored
        we0 = we_cnt;
        bus_start();
        send_byte(8'hA0, ack); chk("R3 foreign address nack", ack, 1);
        send_byte(8'h02, ack); chk("R3 later byte nack", ack, 1);
        send_byte(8'hFF, ack);
        bus_stop();
        chk("R3 no write strobe", we_cnt, we0);
        chk("R3 pointer unchanged", reg_addr, 13);

        // R1 stop returns idle; bits after stop not acked
        bus_start();
        send_byte(8'hD0, ack);
        send_byte(8'd4, ack);
        bus_stop();
        m_scl = 1'b0; step(Q);
        send_byte(8'hD0, ack); chk("R1 no ack after stop", ack, 1);
        m_sda = 1'b1; step(Q); m_scl = 1'b1; step(Q);
        chk("R1 pointer kept", reg_addr, 4);

        // R6 burst write across the wrap
        bus_start();
        send_byte(8'hD0, ack);
        send_byte(8'd18, ack);
        send_byte(8'h11, ack); chk("R5 burst ack 1", ack, 0);
        send_byte(8'h22, ack); chk("R5 burst ack 2", ack, 0);
        send_byte(8'h33, ack); chk("R5 burst ack 3", ack, 0);
        bus_stop();
        chk("R6 wrap idx18", mem[18], 8'h11);
        chk("R6 wrap idx19", mem[19], 8'h22);
        chk("R6 wrap idx0", mem[0], 8'h33);
        chk("R6 pointer after wrap", reg_addr, 1);

        // R7 burst read across the wrap, then NACK
        glitch = 0;
        bus_start();
        send_byte(8'hD0, ack);
        send_byte(8'd18, ack);
        rep_start();
        send_byte(8'hD1, ack);
        recv_byte(1'b1, d); chk("R7 burst read 1", d, 8'h11);
        recv_byte(1'b1, d); chk("R7 burst read 2", d, 8'h22);
        recv_byte(1'b0, d); chk("R7 burst read 3", d, 8'h33);
        chk("R7 released after nack", sda_pull, 0);
        recv_byte(1'b0, d); chk("R7 silent after nack", d, 8'hFF);
        chk("R7 pointer frozen after nack", reg_addr, 1);
        bus_stop();
        chk("R2 data stable while clock high", glitch, 0);

        // R9 power-fail during pointer acknowledge
        bus_start();
        send_byte(8'hD0, ack);
        send_bits(8'd5);
        step(Q);
        chk("R4 pointer loaded", reg_addr, 5);
        chk("R4 ack driven", sda_pull, 1);
        pwr_fail = 1'b1; step(1);
        chk("R9 pull released", sda_pull, 0);
        chk("R9 pointer cleared", reg_addr, 0);
        m_scl = 1'b1; step(Q); m_scl = 1'b0; step(Q);
        bus_stop();
        we0 = we_cnt;
        bus_start();
        send_byte(8'hD0, ack); chk("R9 no ack in power-fail", ack, 1);
        send_byte(8'd3, ack);
        send_byte(8'h77, ack);
        bus_stop();
        chk("R9 no write in power-fail", mem[3], 8'h43);
        chk("R9 no strobe in power-fail", we_cnt, we0);
        pwr_fail = 1'b0; step(Q);

        // R10 power-fail on the cycle a write byte completes
        bus_start();
        send_byte(8'hD0, ack);
        send_byte(8'd9, ack);
        chk("R10 pointer before", reg_addr, 9);
        we0 = we_cnt;
        for (int i = 7; i >= 0; i--) begin
            m_sda = i[0]; step(Q);
            m_scl = 1'b1; step(Q);
            m_scl = 1'b0;
            if (i > 0) step(Q);
        end
        // two sync stages then the edge register: fall acted on at the third edge
        step(1); step(1);
        pwr_fail = 1'b1; step(1);
        pwr_fail = 1'b0; step(Q);
        chk("R10 no strobe", we_cnt, we0);
        chk("R10 array unchanged", mem[9], 8'h49);
        chk("R10 pointer cleared", reg_addr, 0);
        bus_stop();

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule